// File: doc/BRIEF.md
# Multi-Level Daisy-Chain Bus Arbiter

This block settles which device on a shared bus becomes master. Devices are sorted into priority levels. Each level has one request line, formed as the OR of its devices' requests, and one grant line. A central controller picks the highest level that is requesting and drives that level's grant line. The grant then travels along the level's chain of device cells. A cell whose device is not requesting passes the grant on in the same cycle. The first requesting cell, the one closest to the controller, keeps the grant and stops it from going further.

The winning device raises its busy line for as long as it owns the bus. The busy lines are ORed into one bus-busy signal. The controller holds the grant until it sees busy. It then withdraws the grant and waits for the bus to be released. Once busy falls, it arbitrates again at the next clock edge. Priority is fixed by level and by position in the chain, so a device that keeps requesting can starve the devices below it.

The controller is a three-state machine. The states are IDLE (no grant is offered), OFFER (a grant is driven on the selected level) and TENURE (a device owns the bus). The transitions are:
- IDLE to OFFER when some level requests and the bus is not busy.
- OFFER to TENURE when busy is seen.
- OFFER to IDLE when the selected level's request disappears.
- TENURE to OFFER when busy falls while requests are pending.
- TENURE to IDLE when busy falls with no request pending.

Top module: `daisy_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, no level grant and no device grant is asserted.
- R2: If no device requests, no level grant line is driven. If the selected level's request drops while a grant is offered, that grant line falls in the same cycle. The controller then returns to IDLE.
- R3: When several levels request, the grant goes to the lowest-numbered level. Level 0 has the highest priority. Device d of level l is bit l*DEVS+d of the device vectors.
- R4: Within a level, the requesting device with the lowest chain index (closest to the controller) takes the grant. At most one device holds a grant at any time.
- R5: A device that is not requesting passes the grant downstream in the same cycle. A device further down the chain, such as index 3 of its level, receives the grant in the cycle the level grant is driven.
- R6: A grant is issued only at a clock edge where bus-busy is low. While any device holds busy, no new grant appears.
- R7: An offered grant stays asserted for as many cycles as the winner takes to assert busy. It falls in the cycle after the edge at which busy is sampled high.
- R8: When busy falls while requests are pending, the next grant appears right after the next clock edge. It goes to the highest-priority requester at that edge.
- R9: A highest-priority device that keeps requesting wins every arbitration, and lower levels stay locked out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | LEVELS*DEVS | Per-device request, bit l*DEVS+d |
| dev_busy | input | LEVELS*DEVS | Per-device busy, asserted during tenure |
| level_grant | output | LEVELS | Grant line driven into each level's chain |
| dev_grant | output | LEVELS*DEVS | Grant absorbed by each device cell |
| bus_busy | output | 1 | OR of all device busy lines |

## Verification
The assertions check three things on every cycle: at most one level grant and at most one device grant, a device grant only where that device requests, and no grant without a request. They also check that a grant only ever rises after a not-busy edge, and that an offered grant is withdrawn once busy is seen. Only the directed scenarios can show the rest. That covers which level and which chain position wins for a given request pattern, the same-cycle ripple past idle cells, the exact cycle of re-arbitration after release, and the starvation of a lower level by a persistent requester.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_OFFER  = 2'd1,
        ARB_TENURE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/daisy_cell.sv
module daisy_cell (
    input  logic gin,
    input  logic req,
    output logic gout,
    output logic taken
);
    always_comb begin
        taken = gin & req;
        gout  = gin & ~req;
    end
endmodule

// File: rtl/level_chain.sv
module level_chain #(
    parameter int DEVS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl_gnt,
    input  logic [DEVS-1:0] req,
    output logic            lvl_req,
    output logic [DEVS-1:0] taken
);
    logic [DEVS:0] ripple;

    assign ripple[0] = lvl_gnt;
    assign lvl_req   = |req;

    for (genvar d = 0; d < DEVS; d++) begin : g_cell
        daisy_cell u_cell (
            .gin   (ripple[d]),
            .req   (req[d]),
            .gout  (ripple[d+1]),
            .taken (taken[d])
        );
    end

    // R4
    one_taker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));

    // R4
    taker_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken & ~req) == '0);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import daisy_arb_pkg::*;
#(
    parameter int LEVELS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] lvl_req,
    input  logic              bus_busy,
    output logic [LEVELS-1:0] lvl_gnt
);
    localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    arb_state_t      state_q, state_d;
    logic [LW-1:0]   sel_q, sel_d, top_lvl;
    logic            any_req;

    assign any_req = |lvl_req;

    always_comb begin
        top_lvl = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (lvl_req[i]) top_lvl = LW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (any_req && !bus_busy) begin
                    state_d = ARB_OFFER;
                    sel_d   = top_lvl;
                end
            end
            ARB_OFFER: begin
                if (bus_busy)              state_d = ARB_TENURE;
                else if (!lvl_req[sel_q])  state_d = ARB_IDLE;
            end
            ARB_TENURE: begin
                if (!bus_busy) begin
                    if (any_req) begin
                        state_d = ARB_OFFER;
                        sel_d   = top_lvl;
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        for (int i = 0; i < LEVELS; i++) begin
            lvl_gnt[i] = (state_q == ARB_OFFER) && (sel_q == LW'(i)) && lvl_req[i];
        end
    end

    // R3
    one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_gnt));

    // R6
    grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lvl_gnt) |-> $past(!bus_busy));

    // R7
    withdraw_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lvl_gnt) && bus_busy) |=> !(|lvl_gnt));
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
    parameter int LEVELS = 3,
    parameter int DEVS   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LEVELS*DEVS-1:0] dev_req,
    input  logic [LEVELS*DEVS-1:0] dev_busy,
    output logic [LEVELS-1:0]      level_grant,
    output logic [LEVELS*DEVS-1:0] dev_grant,
    output logic                   bus_busy
);
    logic [LEVELS-1:0] lvl_req;

    assign bus_busy = |dev_busy;

    arb_fsm #(.LEVELS(LEVELS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_req  (lvl_req),
        .bus_busy (bus_busy),
        .lvl_gnt  (level_grant)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        level_chain #(.DEVS(DEVS)) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_gnt (level_grant[l]),
            .req     (dev_req[l*DEVS +: DEVS]),
            .lvl_req (lvl_req[l]),
            .taken   (dev_grant[l*DEVS +: DEVS])
        );
    end

    // R2
    no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|dev_req) |-> !(|level_grant));

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_grant));
endmodule

// File: tb/daisy_arbiter_tb.sv
`timescale 1ns/1ps
module daisy_arbiter_tb;
    localparam int LEVELS = 3;
    localparam int DEVS   = 4;
    localparam int N      = LEVELS * DEVS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      dev_req = '0;
    logic [N-1:0]      dev_busy = '0;
    logic [LEVELS-1:0] level_grant;
    logic [N-1:0]      dev_grant;
    logic              bus_busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    daisy_arbiter #(.LEVELS(LEVELS), .DEVS(DEVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_busy(dev_busy),
        .level_grant(level_grant), .dev_grant(dev_grant), .bus_busy(bus_busy)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_grant(string tag, logic [LEVELS-1:0] lg, logic [N-1:0] dg);
        checks++;
        if (level_grant !== lg || dev_grant !== dg) begin
            errors++;
            $display("FAIL %s: level_grant=%b dev_grant=%b expected level_grant=%b dev_grant=%b",
                     tag, level_grant, dev_grant, lg, dg);
        end
    endtask

    function automatic logic [N-1:0] bit_at(int idx);
        logic [N-1:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    task automatic settle();
        dev_req  = '0;
        dev_busy = '0;
        step();
        step();
    endtask

    task automatic test_reset();
        step();
        expect_grant("R1 in reset", '0, '0);
        rst_n = 1'b1;
        dev_req = bit_at(0);
        #1;
        expect_grant("R1 first cycle after reset", '0, '0);
        dev_req = '0;
        step();
    endtask

    task automatic test_idle();
        for (int k = 0; k < 3; k++) begin
            step();
            expect_grant("R2 no request", '0, '0);
        end
    endtask

    task automatic test_levels();
        dev_req = bit_at(2*DEVS+1) | bit_at(1*DEVS+3);
        step();
        expect_grant("R3 level 1 beats level 2", 3'b010, bit_at(1*DEVS+3));
        dev_busy = bit_at(1*DEVS+3);
        step();
        expect_grant("R7 grant gone after busy", '0, '0);
        dev_busy = '0;
        dev_req  = bit_at(2*DEVS+1);
        step();
        expect_grant("R8 rearbitrate next edge", 3'b100, bit_at(2*DEVS+1));
        dev_busy = bit_at(2*DEVS+1);
        step();
        settle();
    endtask

    task automatic test_chain();
        dev_req = bit_at(1) | bit_at(3);
        step();
        expect_grant("R4 nearest requester wins", 3'b001, bit_at(1));
        dev_busy = bit_at(1);
        step();
        settle();
        dev_req = bit_at(3);
        step();
        expect_grant("R5 ripple past idle cells", 3'b001, bit_at(3));
        dev_busy = bit_at(3);
        step();
        settle();
    endtask

    task automatic test_busy_block();
        dev_busy = bit_at(1*DEVS+1);
        dev_req  = bit_at(0);
        for (int k = 0; k < 3; k++) begin
            step();
            expect_grant("R6 no grant while busy", '0, '0);
        end
        dev_busy = '0;
        step();
        expect_grant("R6 grant after release", 3'b001, bit_at(0));
        dev_busy = bit_at(0);
        step();
        settle();
    endtask

    task automatic test_hold();
        dev_req = bit_at(1*DEVS+2);
        for (int k = 0; k < 3; k++) begin
            step();
            expect_grant("R7 grant held until busy", 3'b010, bit_at(1*DEVS+2));
        end
        dev_busy = bit_at(1*DEVS+2);
        #1;
        expect_grant("R7 grant still on before edge", 3'b010, bit_at(1*DEVS+2));
        step();
        expect_grant("R7 grant dropped", '0, '0);
        dev_busy = '0;
        dev_req  = '0;
        step();
        expect_grant("R2 idle after tenure", '0, '0);
    endtask

    task automatic test_withdraw();
        dev_req = bit_at(2*DEVS+2);
        step();
        expect_grant("R2 offer before withdraw", 3'b100, bit_at(2*DEVS+2));
        dev_req = '0;
        #1;
        expect_grant("R2 withdrawn same cycle", '0, '0);
        step();
        expect_grant("R2 idle after withdraw", '0, '0);
    endtask

    task automatic test_lockout();
        dev_req = bit_at(0) | bit_at(2*DEVS);
        step();
        expect_grant("R9 first win", 3'b001, bit_at(0));
        for (int k = 0; k < 3; k++) begin
            dev_busy = bit_at(0);
            step();
            dev_busy = '0;
            step();
            expect_grant("R9 high device keeps winning", 3'b001, bit_at(0));
        end
        dev_busy = bit_at(0);
        step();
        dev_busy = '0;
        dev_req  = bit_at(2*DEVS);
        step();
        expect_grant("R8 low level after release", 3'b100, bit_at(2*DEVS));
        dev_busy = bit_at(2*DEVS);
        step();
        settle();
    endtask

    initial begin
        #1;
        test_reset();
        test_idle();
        test_levels();
        test_chain();
        test_busy_block();
        test_hold();
        test_withdraw();
        test_lockout();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule